// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Slave

This block is the configuration port of a device register space. An external controller drives a serial clock, an active-low select and one data line that turns around inside a frame. Every frame starts with a 16-bit instruction. The instruction holds a read/write flag, a two-bit length code and a 13-bit register address. One or more 8-bit data words follow the instruction. A write frame stores each received byte into the register file. A read frame turns the data line into an output and shifts register contents back to the controller.

The block runs entirely on the system clock `clk`. The serial clock, select and incoming data are treated as signals already synchronous to `clk` and are sampled on it. Serial clock edges are detected from one registered copy of the serial clock. The data pad sits outside the block, which presents it as a separate input, output and output enable. A frame may pause between bytes or run without limit. The bit order can be changed at run time through one bit of a configuration register. The whole register file is also visible at all times on a flat parallel readout port.

Top module: `spi3w_cfg_slave`

## Requirements
- R1: After reset every register reads zero, `sdio_oe` and `sdio_o` are low, and bit order is most-significant first.
- R2: While `cs_n` is low, the first 16 rising serial clock edges shift in the instruction. In MSB-first order the instruction bits arrive as read flag (1 = read), then length bits L1 and L0, then address bits 12 down to 0. In LSB-first order the same 16-bit word arrives starting from address bit 0 and ending with the read flag.
- R3: Length code {L1,L0} = 00, 01 or 10 transfers exactly 1, 2 or 3 data bytes. Bytes clocked after that have no effect on any register, and `sdio_oe` is low once the last byte of a counted read has been clocked.
- R4: Length code 11 streams data bytes with no limit for as long as `cs_n` stays low. A rise of `cs_n` on a byte boundary ends the stream.
- R5: A write stores each complete data byte in the register at the current address. A write to an address at or above `NUM_REGS` changes nothing, and a read from such an address returns 0x00.
- R6: In a read frame `sdio_oe` goes high once the 16th instruction bit has been clocked. Each output bit is launched on a falling serial clock edge, with the first bit launched on the falling edge that follows the last instruction bit. `sdio_o` changes at no other time.
- R7: When `cs_n` is high, `sdio_oe` is low.
- R8: After each data byte the address moves by one. In MSB-first order it decreases and in LSB-first order it increases, wrapping within 13 bits.
- R9: Bit 0 of the register at address 0 selects LSB-first order when set. A new value takes effect from the next frame, for both the instruction and the data.
- R10: If `cs_n` rises between bytes of the instruction or of a counted data phase and later falls again, the frame continues from where it paused. In a read, the pending output bit is presented again when `cs_n` falls.
- R11: If `cs_n` rises in the middle of a byte, the partial byte is discarded with no register write. The next frame starts a fresh instruction.
- R12: `reg_dump` shows register n on bits [8n+7:8n] and changes only as a result of a completed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial data to the pad |
| sdio_oe | output | 1 | Pad output enable (high = block drives the line) |
| reg_dump | output | NUM_REGS*8 | Parallel view of all registers |

## Verification
The hardest cases to reach from the ports are a pause between bytes and a resumption after it, because the block must tell a legal pause at a byte boundary apart from an abort in the middle of a byte. The stimulus covers several variants: a pause between the two instruction bytes, pauses between data bytes of both a write and a read, and aborts after 7 instruction bits and after 5 data bits. Each variant is followed by a fresh frame that shows whether the pause kept state or the abort dropped it. The change of bit order is reached the same way, through a write to the configuration bit followed by frames sent in the other order.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

   localparam int INSTR_BITS = 16;
   localparam int ADDR_W     = 13;
   localparam int BYTE_W     = 8;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_INSTR = 2'd1,
      ST_DATA  = 2'd2,
      ST_DONE  = 2'd3
   } spi3w_state_e;

   localparam logic [1:0] LEN_STREAM = 2'b11;

   function automatic logic [BYTE_W-1:0] bitrev8(input logic [BYTE_W-1:0] d);
      logic [BYTE_W-1:0] r;
      for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
      return r;
   endfunction

endpackage

// File: rtl/spi3w_edge_det.sv
module spi3w_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic rise,
   output logic fall
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig;
   end

   assign rise = sig & ~sig_q;
   assign fall = ~sig & sig_q;
endmodule

// File: rtl/spi3w_frame_ctl.sv
module spi3w_frame_ctl
   import spi3w_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sdio_i,
   input  logic              sclk_rise,
   input  logic              cfg_lsb,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              rd_active,
   output logic              byte_start,
   output logic              lsb_mode
);
   localparam int CNT_W = $clog2(INSTR_BITS) + 1;
   localparam logic [CNT_W-1:0] LAST_IBIT = CNT_W'(INSTR_BITS - 1);
   localparam logic [CNT_W-1:0] MID_IBIT  = CNT_W'(INSTR_BITS / 2);
   localparam logic [CNT_W-1:0] LAST_DBIT = CNT_W'(BYTE_W - 1);

   spi3w_state_e      state_q;
   logic [CNT_W-1:0]  bcnt_q;
   logic [INSTR_BITS-1:0] isr_q, isr_nxt;
   logic [BYTE_W-1:0] dsr_q, dsr_nxt;
   logic [ADDR_W-1:0] addr_q, addr_step;
   logic              is_rd_q, lsb_q, wr_en_q;
   logic [1:0]        len_q, left_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [BYTE_W-1:0] wr_data_q;
   logic              at_boundary;

   assign isr_nxt   = lsb_q ? {sdio_i, isr_q[INSTR_BITS-1:1]} : {isr_q[INSTR_BITS-2:0], sdio_i};
   assign dsr_nxt   = lsb_q ? {sdio_i, dsr_q[BYTE_W-1:1]} : {dsr_q[BYTE_W-2:0], sdio_i};
   assign addr_step = lsb_q ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);

   // a legal pause point: mid-instruction byte boundary, or data byte boundary of a counted frame
   assign at_boundary = ((state_q == ST_INSTR) && (bcnt_q == MID_IBIT)) ||
                        ((state_q == ST_DATA) && (bcnt_q == '0) && (len_q != LEN_STREAM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bcnt_q    <= '0;
         isr_q     <= '0;
         dsr_q     <= '0;
         addr_q    <= '0;
         is_rd_q   <= 1'b0;
         len_q     <= '0;
         left_q    <= '0;
         lsb_q     <= 1'b0;
         wr_en_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (state_q == ST_IDLE) lsb_q <= cfg_lsb;
         if (cs_n) begin
            if (!at_boundary) begin
               state_q <= ST_IDLE;
               bcnt_q  <= '0;
            end
         end else if (sclk_rise) begin
            unique case (state_q)
               ST_IDLE: begin
                  isr_q   <= isr_nxt;
                  bcnt_q  <= CNT_W'(1);
                  state_q <= ST_INSTR;
               end
               ST_INSTR: begin
                  isr_q <= isr_nxt;
                  if (bcnt_q == LAST_IBIT) begin
                     is_rd_q <= isr_nxt[INSTR_BITS-1];
                     len_q   <= isr_nxt[INSTR_BITS-2:INSTR_BITS-3];
                     left_q  <= isr_nxt[INSTR_BITS-2:INSTR_BITS-3];
                     addr_q  <= isr_nxt[ADDR_W-1:0];
                     bcnt_q  <= '0;
                     state_q <= ST_DATA;
                  end else begin
                     bcnt_q <= bcnt_q + CNT_W'(1);
                  end
               end
               ST_DATA: begin
                  dsr_q <= dsr_nxt;
                  if (bcnt_q == LAST_DBIT) begin
                     bcnt_q <= '0;
                     if (!is_rd_q) begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= addr_q;
                        wr_data_q <= dsr_nxt;
                     end
                     addr_q <= addr_step;
                     if (len_q != LEN_STREAM) begin
                        if (left_q == 2'd0) state_q <= ST_DONE;
                        else                left_q  <= left_q - 2'd1;
                     end
                  end else begin
                     bcnt_q <= bcnt_q + CNT_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign wr_en      = wr_en_q;
   assign wr_addr    = wr_addr_q;
   assign wr_data    = wr_data_q;
   assign cur_addr   = addr_q;
   assign rd_active  = (state_q == ST_DATA) && is_rd_q;
   assign byte_start = (bcnt_q == '0);
   assign lsb_mode   = lsb_q;
endmodule

// File: rtl/spi3w_tx.sv
module spi3w_tx
   import spi3w_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              byte_start,
   input  logic              lsb_mode,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sdo
);
   logic [BYTE_W-1:0] load_val;
   logic [BYTE_W-1:0] sr_q;
   logic              sdo_q;

   assign load_val = lsb_mode ? bitrev8(rd_data) : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         sdo_q <= 1'b0;
      end else if (launch) begin
         if (byte_start) begin
            sdo_q <= load_val[BYTE_W-1];
            sr_q  <= {load_val[BYTE_W-2:0], 1'b0};
         end else begin
            sdo_q <= sr_q[BYTE_W-1];
            sr_q  <= {sr_q[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign sdo = sdo_q;
endmodule

// File: rtl/spi3w_regfile.sv
module spi3w_regfile
   import spi3w_pkg::*;
#(
   parameter int NUM_REGS    = 16,
   parameter int CFG_ADDR    = 0,
   parameter int CFG_LSB_BIT = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [BYTE_W-1:0]        wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [BYTE_W-1:0]        rd_data,
   output logic                     cfg_lsb,
   output logic [NUM_REGS*BYTE_W-1:0] dump
);
   localparam int IDX_W = $clog2(NUM_REGS);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

   logic [BYTE_W-1:0] regs [NUM_REGS];

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       regs[gi] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(gi)))       regs[gi] <= wr_data;
      end
      assign dump[gi*BYTE_W +: BYTE_W] = regs[gi];
   end

   assign rd_data = (rd_addr < LIMIT) ? regs[rd_addr[IDX_W-1:0]] : '0;
   assign cfg_lsb = regs[CFG_ADDR][CFG_LSB_BIT];
endmodule

// File: rtl/spi3w_cfg_slave.sv
module spi3w_cfg_slave
   import spi3w_pkg::*;
#(
   parameter int NUM_REGS    = 16,
   parameter int CFG_ADDR    = 0,
   parameter int CFG_LSB_BIT = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sclk,
   input  logic                        cs_n,
   input  logic                        sdio_i,
   output logic                        sdio_o,
   output logic                        sdio_oe,
   output logic [NUM_REGS*BYTE_W-1:0]  reg_dump
);
   if (NUM_REGS < 2 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("spi3w_cfg_slave: NUM_REGS out of range");
   end
   if (CFG_ADDR < 0 || CFG_ADDR >= NUM_REGS) begin : g_bad_cfg_addr
      $error("spi3w_cfg_slave: CFG_ADDR outside register file");
   end
   if (CFG_LSB_BIT < 0 || CFG_LSB_BIT >= BYTE_W) begin : g_bad_cfg_bit
      $error("spi3w_cfg_slave: CFG_LSB_BIT outside a byte");
   end

   logic              sclk_rise, sclk_fall;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, cur_addr;
   logic [BYTE_W-1:0] wr_data, rd_data;
   logic              rd_active, byte_start, lsb_mode, cfg_lsb;

   spi3w_edge_det u_sclk_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (sclk),
      .rise (sclk_rise),
      .fall (sclk_fall)
   );

   spi3w_frame_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sdio_i    (sdio_i),
      .sclk_rise (sclk_rise),
      .cfg_lsb   (cfg_lsb),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cur_addr  (cur_addr),
      .rd_active (rd_active),
      .byte_start(byte_start),
      .lsb_mode  (lsb_mode)
   );

   spi3w_regfile #(
      .NUM_REGS   (NUM_REGS),
      .CFG_ADDR   (CFG_ADDR),
      .CFG_LSB_BIT(CFG_LSB_BIT)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(cur_addr),
      .rd_data(rd_data),
      .cfg_lsb(cfg_lsb),
      .dump   (reg_dump)
   );

   spi3w_tx u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (sclk_fall && rd_active && !cs_n),
      .byte_start(byte_start),
      .lsb_mode  (lsb_mode),
      .rd_data   (rd_data),
      .sdo       (sdio_o)
   );

   assign sdio_oe = !cs_n && rd_active;
endmodule

// File: rtl/spi3w_cfg_slave_chk.sv
module spi3w_cfg_slave_chk #(
   parameter int DUMP_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk,
   input logic              cs_n,
   input logic              sdio_o,
   input logic              sdio_oe,
   input logic              wr_en,
   input logic [DUMP_W-1:0] reg_dump
);
   // R6: output data moves only on the cycle after a detected falling serial clock edge
   a_r6_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sdio_o != $past(sdio_o)) |-> (!$past(sclk) && $past(sclk, 2)));

   // R5 / R11: a register write follows a rising serial clock edge taken while selected
   a_r5_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(sclk) && !$past(sclk, 2) && !$past(cs_n)));

   // R2: a write never happens while the block drives the data line
   a_r2_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !sdio_oe);

   // R12: the parallel view changes only after a write strobe
   a_r12_dump_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_dump != $past(reg_dump)) |-> $past(wr_en));
endmodule

bind spi3w_cfg_slave spi3w_cfg_slave_chk #(.DUMP_W(NUM_REGS * 8)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sclk    (sclk),
   .cs_n    (cs_n),
   .sdio_o  (sdio_o),
   .sdio_oe (sdio_oe),
   .wr_en   (wr_en),
   .reg_dump(reg_dump)
);

// File: tb/spi3w_cfg_slave_tb_top.sv
module spi3w_cfg_slave_tb_top;
   localparam int NREG = 16;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic sdio_i = 1'b0;
   logic sdio_o, sdio_oe;
   logic [NREG*8-1:0] reg_dump;

   int checks = 0;
   int errors = 0;
   logic finished = 1'b0;
   logic lsb_m = 1'b0;
   logic [7:0] exp_r [NREG];

   always #2 clk = ~clk;

   spi3w_cfg_slave #(.NUM_REGS(NREG)) dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
      .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_dump(reg_dump)
   );

   task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic mwrite(input logic [12:0] a, input logic [7:0] d);
      if (a < 13'(NREG)) exp_r[a[3:0]] = d;
   endtask

   task automatic check_dump(input string req);
      logic [NREG*8-1:0] e;
      for (int i = 0; i < NREG; i++) e[i*8 +: 8] = exp_r[i];
      chk(reg_dump == e, req, 128'(reg_dump), 128'(e));
   endtask

   task automatic sbit(input logic b);
      sdio_i = b;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic rbit(output logic b);
      b = sdio_o;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic sel();
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic desel();
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_bits(input logic [15:0] w, input int from, input int to);
      for (int i = from; i < to; i++) sbit(lsb_m ? w[i] : w[15-i]);
   endtask

   task automatic send_instr(input logic rd, input logic [1:0] len, input logic [12:0] a);
      send_bits({rd, len, a}, 0, 16);
   endtask

   task automatic send_byte(input logic [7:0] d);
      for (int i = 0; i < 8; i++) sbit(lsb_m ? d[i] : d[7-i]);
   endtask

   task automatic recv_byte(output logic [7:0] d);
      logic b;
      for (int i = 0; i < 8; i++) begin
         rbit(b);
         if (lsb_m) d[i] = b;
         else       d[7-i] = b;
      end
   endtask

   task automatic t_reset();
      chk(sdio_oe == 1'b0, "R1 oe after reset", 128'(sdio_oe), 0);
      chk(sdio_o == 1'b0, "R1 sdo after reset", 128'(sdio_o), 0);
      check_dump("R1 registers zero after reset");
   endtask

   task automatic t_write_single();
      sel(); send_instr(1'b0, 2'b00, 13'd5); send_byte(8'hA5); desel();
      mwrite(13'd5, 8'hA5);
      check_dump("R2 R5 single byte write");
   endtask

   task automatic t_write_counted();
      sel(); send_instr(1'b0, 2'b10, 13'd9);
      send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
      send_byte(8'h44);   // beyond the length code: must not land in register 6
      desel();
      mwrite(13'd9, 8'h11); mwrite(13'd8, 8'h22); mwrite(13'd7, 8'h33);
      check_dump("R3 R8 three bytes, extra byte ignored, address decrements");
   endtask

   task automatic t_read_counted();
      logic [7:0] d;
      sel(); send_instr(1'b1, 2'b01, 13'd9);
      chk(sdio_oe == 1'b1, "R6 oe after read instruction", 128'(sdio_oe), 1);
      recv_byte(d); chk(d == exp_r[9], "R6 read byte 0", 128'(d), 128'(exp_r[9]));
      recv_byte(d); chk(d == exp_r[8], "R8 read byte 1", 128'(d), 128'(exp_r[8]));
      chk(sdio_oe == 1'b0, "R3 oe low after last counted byte", 128'(sdio_oe), 0);
      desel();
      chk(sdio_oe == 1'b0, "R7 oe low when deselected", 128'(sdio_oe), 0);
   endtask

   task automatic t_stream();
      logic [7:0] d;
      sel(); send_instr(1'b0, 2'b11, 13'd3);
      send_byte(8'hC1); send_byte(8'hC2); send_byte(8'hC3);
      desel();
      mwrite(13'd3, 8'hC1); mwrite(13'd2, 8'hC2); mwrite(13'd1, 8'hC3);
      check_dump("R4 streaming write");
      sel(); send_instr(1'b1, 2'b11, 13'd12);
      for (int k = 0; k < 5; k++) begin
         recv_byte(d);
         chk(d == exp_r[12-k], "R4 streaming read", 128'(d), 128'(exp_r[12-k]));
      end
      desel();
      sel(); send_instr(1'b0, 2'b00, 13'd12); send_byte(8'h5C); desel();
      mwrite(13'd12, 8'h5C);
      check_dump("R4 new frame after stream ends");
   endtask

   task automatic t_stall();
      logic [7:0] d;
      sel(); send_bits({1'b0, 2'b10, 13'd15}, 0, 8); desel();
      sel(); send_bits({1'b0, 2'b10, 13'd15}, 8, 16); desel();
      sel(); send_byte(8'hE1); desel();
      sel(); send_byte(8'hE2); desel();
      sel(); send_byte(8'hE3); desel();
      mwrite(13'd15, 8'hE1); mwrite(13'd14, 8'hE2); mwrite(13'd13, 8'hE3);
      check_dump("R10 write resumes after stalls");
      sel(); send_instr(1'b1, 2'b10, 13'd15);
      recv_byte(d); desel();
      chk(d == 8'hE1, "R10 read byte before stall", 128'(d), 128'hE1);
      sel(); recv_byte(d); desel();
      chk(d == 8'hE2, "R10 read byte after stall", 128'(d), 128'hE2);
      sel(); recv_byte(d); desel();
      chk(d == 8'hE3, "R10 read third byte", 128'(d), 128'hE3);
   endtask

   task automatic t_abort();
      sel(); send_instr(1'b0, 2'b00, 13'd4);
      for (int i = 0; i < 5; i++) sbit(1'b1);
      desel();
      check_dump("R11 partial data byte discarded");
      sel(); send_bits({1'b0, 2'b00, 13'd6}, 0, 7); desel();
      sel(); send_instr(1'b0, 2'b00, 13'd4); send_byte(8'h3C); desel();
      mwrite(13'd4, 8'h3C);
      check_dump("R11 fresh instruction after abort");
   endtask

   task automatic t_out_of_range();
      logic [7:0] d;
      sel(); send_instr(1'b0, 2'b00, 13'h100); send_byte(8'hFF); desel();
      check_dump("R5 write beyond file ignored");
      sel(); send_instr(1'b1, 2'b00, 13'h100); recv_byte(d); desel();
      chk(d == 8'h00, "R5 read beyond file", 128'(d), 0);
   endtask

   task automatic t_lsb_first();
      logic [7:0] d;
      sel(); send_instr(1'b0, 2'b00, 13'd0); send_byte(8'h01); desel();
      mwrite(13'd0, 8'h01);
      check_dump("R9 config write");
      lsb_m = 1'b1;
      sel(); send_instr(1'b0, 2'b01, 13'd1); send_byte(8'h5A); send_byte(8'h96); desel();
      mwrite(13'd1, 8'h5A); mwrite(13'd2, 8'h96);
      check_dump("R9 R8 LSB-first write increments address");
      sel(); send_instr(1'b1, 2'b10, 13'd1);
      for (int k = 0; k < 3; k++) begin
         recv_byte(d);
         chk(d == exp_r[1+k], "R9 LSB-first read", 128'(d), 128'(exp_r[1+k]));
      end
      desel();
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_single();
      t_write_counted();
      t_read_counted();
      t_stream();
      t_stall();
      t_abort();
      t_out_of_range();
      t_lsb_first();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule